// File: doc/BRIEF.md
# Double-Buffered Crosspoint Routing Controller

This block is the control logic of a non-blocking routing switch with 16 sources and 9 destinations. Each destination has a 5-bit routing word that names one source or leaves the destination switched off. Words are first placed in a staging rank, where they have no effect on the switch. A single commit strobe then copies the whole staging rank into a live rank, and every destination changes in the same cycle.

The staging rank can be filled in two ways. In serial mode it is one long shift register: bits enter at `sdi`, and the bit at the far end is always visible on `sdo`, so several controllers can be chained on one data line. In parallel mode a strobed write stores a word at one destination address, or at all of them when the broadcast flag is set. A chip select must be high for a shift or a commit to take effect. Reset switches every destination off but keeps whatever is staged, so a later commit brings the staged routing back.

Top module: `xbar_route_ctl`

## Requirements
- R1: A routing word holds the enable in bit 4 and the source index in bits 3:0. With the enable at 0, `out_en[k]` is low and the 16 bits of `out_hot` for that destination are all 0. With the enable at 1, `out_sel[4k+3:4k]` equals the index and exactly bit `16k+index` of `out_hot` is set.
- R2: Loading the staging rank, by shift or by write, leaves `out_en`, `out_sel` and `out_hot` unchanged until a commit takes effect.
- R3: When `cs` and `commit` are both high at a clock edge, all nine staged words reach the outputs together, right after that edge.
- R4: When `par_mode=1` and `wr_stb=1` with `wr_bcast=0`, `wr_data` is stored only at destination `wr_addr`. Addresses 9 to 15 store nothing.
- R5: When `par_mode=1`, `wr_stb=1` and `wr_bcast=1`, `wr_data` is stored at all nine destinations, whatever `wr_addr` holds.
- R6: When `par_mode=0`, `cs=1` and `shift_stb=1`, the staging chain moves by one bit and `sdi` enters at the near end. The chain is 45 bits long. Destination 8 lies at the far end and each word enters MSB first, so a full load sends destination 8 first and destination 0 last.
- R7: `sdo` shows the far-end bit of the chain, which is bit 4 of the staged word for destination 8. Each shift moves the next staged bit onto `sdo`, in the same order in which bits are loaded.
- R8: A synchronous reset sets every destination to disabled. It does not change the staging rank, so a later commit restores the staged routing.
- R9: While `cs=0`, shift and commit strobes have no effect: the staging chain, `sdo` and the outputs all hold.
- R10: Writes are ignored when `par_mode=0`, and shifts are ignored when `par_mode=1`.
- R11: If reset and a qualified commit arrive in the same cycle, reset wins and every destination is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the live rank |
| cs | input | 1 | Chip select; qualifies shift and commit |
| par_mode | input | 1 | 1 selects parallel writes, 0 selects serial shifting |
| shift_stb | input | 1 | Shift strobe (one bit per cycle) |
| sdi | input | 1 | Serial data into the chain |
| sdo | output | 1 | Far-end bit of the chain, used for daisy-chaining |
| wr_stb | input | 1 | Parallel write strobe |
| wr_addr | input | 4 | Destination address for a write |
| wr_data | input | 5 | Routing word to write |
| wr_bcast | input | 1 | Write to all destinations |
| commit | input | 1 | Global update strobe |
| out_en | output | 9 | Per-destination enable |
| out_sel | output | 36 | Per-destination source index, 4 bits each |
| out_hot | output | 144 | Per-destination one-hot source select, 16 bits each |

## Verification
The hardest case to reach is showing that reset leaves the staging rank alone, because the staging rank can only be observed through `sdo` or through a later commit. The stimulus commits a known parallel pattern and then resets while that pattern is still staged. It checks that every output goes dark and then commits again with no reload in between, so the old routing can only come back if the staging rank kept it. The serial chain order is covered the same way: a full 45-bit load is shifted over a staged parallel pattern, and every bit of the old contents is compared on `sdo` as it leaves the chain.

// File: rtl/xbar_route_pkg.sv
package xbar_route_pkg;

    localparam int unsigned N_IN    = 16;
    localparam int unsigned N_OUT   = 9;
    localparam int unsigned IDX_W   = $clog2(N_IN);
    localparam int unsigned WORD_W  = IDX_W + 1;
    localparam int unsigned CHAIN_W = N_OUT * WORD_W;
    localparam int unsigned ADDR_W  = $clog2(N_OUT);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
    } route_word_t;

    typedef route_word_t [N_OUT-1:0] route_bank_t;

    typedef struct packed {
        logic              do_shift;
        logic              do_write;
        logic              do_commit;
        logic              bcast;
        logic [ADDR_W-1:0] addr;
        route_word_t       data;
        logic              sdi;
    } route_cmd_t;

    function automatic logic [N_IN-1:0] word_onehot(input route_word_t w);
        logic [N_IN-1:0] v;
        v = '0;
        if (w.en) v[w.idx] = 1'b1;
        return v;
    endfunction

    function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                      input int unsigned k,
                                      input logic bc);
        return bc || (int'(a) == int'(k));
    endfunction

endpackage

// File: rtl/route_cmd_gate.sv
module route_cmd_gate
    import xbar_route_pkg::*;
(
    input  logic              cs,
    input  logic              par_mode,
    input  logic              shift_stb,
    input  logic              sdi,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_bcast,
    input  logic              commit,
    output route_cmd_t        cmd
);

    always_comb begin
        cmd           = '0;
        cmd.do_shift  = cs && !par_mode && shift_stb;
        cmd.do_write  = par_mode && wr_stb;
        cmd.do_commit = cs && commit;
        cmd.bcast     = wr_bcast;
        cmd.addr      = wr_addr;
        cmd.data      = route_word_t'(wr_data);
        cmd.sdi       = sdi;
    end

endmodule

// File: rtl/route_stage_rank.sv
module route_stage_rank
    import xbar_route_pkg::*;
(
    input  logic        clk,
    input  route_cmd_t  cmd,
    output route_bank_t stage_o,
    output logic        sdo
);

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] chain_d;

    always_comb begin
        chain_d = chain_q;
        if (cmd.do_shift) begin
            chain_d = {chain_q[CHAIN_W-2:0], cmd.sdi};
        end
        for (int unsigned k = 0; k < N_OUT; k++) begin
            if (cmd.do_write && addr_hit(cmd.addr, k, cmd.bcast)) begin
                chain_d[k*WORD_W +: WORD_W] = cmd.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign stage_o = route_bank_t'(chain_q);
    assign sdo     = chain_q[CHAIN_W-1];

endmodule

// File: rtl/route_live_rank.sv
module route_live_rank
    import xbar_route_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        do_commit,
    input  route_bank_t stage_i,
    output route_bank_t live_o
);

    route_bank_t live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (do_commit) begin
            live_q <= stage_i;
        end
    end

    assign live_o = live_q;

    // R3: a qualified commit lands every staged word in the live rank
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
        do_commit |=> (live_q == $past(stage_i)));

    // R2: without a commit the live rank holds
    a_r2_live_holds: assert property (@(posedge clk) disable iff (rst)
        !do_commit |=> $stable(live_q));

    // R8: the cycle after reset every destination is disabled
    a_r8_reset_disables: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_q == '0));

endmodule

// File: rtl/route_out_decode.sv
module route_out_decode
    import xbar_route_pkg::*;
(
    input  route_bank_t                 live_i,
    output logic [N_OUT-1:0]            en_o,
    output logic [N_OUT*IDX_W-1:0]      sel_o,
    output logic [N_OUT*N_IN-1:0]       hot_o
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_dest
        logic [N_IN-1:0] hot_k;

        always_comb begin
            hot_k = word_onehot(live_i[k]);
        end

        assign en_o[k]                  = live_i[k].en;
        assign sel_o[k*IDX_W +: IDX_W]  = live_i[k].idx;
        assign hot_o[k*N_IN +: N_IN]    = hot_k;

        // R1: at most one source per destination, none when disabled
        always_comb begin
            a_r1_single_source: assert ($onehot0(hot_k));
            a_r1_off_is_dark: assert (live_i[k].en || (hot_k == '0));
        end
    end

endmodule

// File: rtl/xbar_route_ctl.sv
module xbar_route_ctl
    import xbar_route_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs,
    input  logic                       par_mode,
    input  logic                       shift_stb,
    input  logic                       sdi,
    output logic                       sdo,
    input  logic                       wr_stb,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic                       wr_bcast,
    input  logic                       commit,
    output logic [N_OUT-1:0]           out_en,
    output logic [N_OUT*IDX_W-1:0]     out_sel,
    output logic [N_OUT*N_IN-1:0]      out_hot
);

    route_cmd_t  cmd;
    route_bank_t stage_bank;
    route_bank_t live_bank;

    route_cmd_gate u_gate (
        .cs        (cs),
        .par_mode  (par_mode),
        .shift_stb (shift_stb),
        .sdi       (sdi),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_bcast  (wr_bcast),
        .commit    (commit),
        .cmd       (cmd)
    );

    route_stage_rank u_stage (
        .clk     (clk),
        .cmd     (cmd),
        .stage_o (stage_bank),
        .sdo     (sdo)
    );

    route_live_rank u_live (
        .clk       (clk),
        .rst       (rst),
        .do_commit (cmd.do_commit),
        .stage_i   (stage_bank),
        .live_o    (live_bank)
    );

    route_out_decode u_dec (
        .live_i (live_bank),
        .en_o   (out_en),
        .sel_o  (out_sel),
        .hot_o  (out_hot)
    );

    // R7: a shift brings the next staged bit onto sdo
    a_r7_sdo_advances: assert property (@(posedge clk) disable iff (rst)
        (cs && !par_mode && shift_stb) |=>
            (sdo == $past(stage_bank[N_OUT-1].idx[IDX_W-1])));

    // R9: with chip select low and no write, the chain end holds
    a_r9_cs_blocks_shift: assert property (@(posedge clk) disable iff (rst)
        (!cs && !(par_mode && wr_stb)) |=> $stable(sdo));

    // R9: with chip select low the outputs hold
    a_r9_cs_blocks_commit: assert property (@(posedge clk) disable iff (rst)
        !cs |=> ($stable(out_en) && $stable(out_sel)));

    // R10: in parallel mode a shift alone leaves the chain end alone
    a_r10_mode_blocks_shift: assert property (@(posedge clk) disable iff (rst)
        (par_mode && !wr_stb) |=> $stable(sdo));

endmodule

// File: tb/xbar_route_ctl_tb_top.sv
`timescale 1ns/100ps
module xbar_route_ctl_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         cs;
    logic         par_mode;
    logic         shift_stb;
    logic         sdi;
    logic         sdo;
    logic         wr_stb;
    logic [3:0]   wr_addr;
    logic [4:0]   wr_data;
    logic         wr_bcast;
    logic         commit;
    logic [8:0]   out_en;
    logic [35:0]  out_sel;
    logic [143:0] out_hot;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R8";

    logic [4:0] m_stage [9];
    logic [4:0] m_out   [9];
    bit         m_known = 1'b0;
    bit         m_ok    = 1'b0;

    always #2.5 clk = ~clk;

    xbar_route_ctl dut_i (
        .clk(clk), .rst(rst), .cs(cs), .par_mode(par_mode),
        .shift_stb(shift_stb), .sdi(sdi), .sdo(sdo),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_bcast(wr_bcast), .commit(commit),
        .out_en(out_en), .out_sel(out_sel), .out_hot(out_hot)
    );

    task automatic check(input string tag, input logic [143:0] got, input logic [143:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_route(input string tag, input int k, input bit en, input int idx);
        logic [15:0] hot_exp;
        hot_exp = en ? (16'h1 << idx) : 16'h0;
        check({tag, " en"},  144'(out_en[k]), 144'(en));
        if (en) check({tag, " sel"}, 144'(out_sel[k*4 +: 4]), 144'(idx));
        check({tag, " hot"}, 144'(out_hot[k*16 +: 16]), 144'(hot_exp));
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        logic carry;
        logic nb;
        if (rst) begin
            for (int k = 0; k < 9; k++) m_out[k] = 5'd0;
            m_ok = 1'b1;
        end else if (cs && commit) begin
            for (int k = 0; k < 9; k++) m_out[k] = m_stage[k];
        end
        if (!par_mode && cs && shift_stb) begin
            carry = sdi;
            for (int k = 0; k < 9; k++) begin
                nb          = m_stage[k][4];
                m_stage[k]  = {m_stage[k][3:0], carry};
                carry       = nb;
            end
        end
        if (par_mode && wr_stb) begin
            for (int k = 0; k < 9; k++)
                if (wr_bcast || int'(wr_addr) == k) m_stage[k] = wr_data;
            if (wr_bcast) m_known = 1'b1;
        end
    end

    // compare model against the ports away from the active edge
    always @(negedge clk) begin
        logic [8:0]   e_en;
        logic [35:0]  e_sel;
        logic [143:0] e_hot;
        if (m_ok) begin
            for (int k = 0; k < 9; k++) begin
                e_en[k]          = m_out[k][4];
                e_sel[k*4 +: 4]  = m_out[k][3:0];
                e_hot[k*16 +: 16] = m_out[k][4] ? (16'h1 << m_out[k][3:0]) : 16'h0;
            end
            check({cur_req, " model en"},  144'(out_en), 144'(e_en));
            check({cur_req, " model sel"}, 144'(out_sel), 144'(e_sel));
            check({cur_req, " model hot"}, out_hot, e_hot);
            if (m_known) check({cur_req, " model sdo"}, 144'(sdo), 144'(m_stage[8][4]));
        end
    end

    task automatic pwrite(input int a, input logic [4:0] d, input bit bc);
        par_mode = 1'b1; wr_stb = 1'b1; wr_addr = 4'(a); wr_data = d; wr_bcast = bc;
        @(negedge clk);
        wr_stb = 1'b0; wr_bcast = 1'b0;
    endtask

    task automatic do_commit(input bit c);
        cs = c; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0; cs = 1'b1;
    endtask

    task automatic shift_bit(input logic b, input bit c);
        cs = c; shift_stb = 1'b1; sdi = b;
        @(negedge clk);
        shift_stb = 1'b0; cs = 1'b1;
    endtask

    function automatic logic [4:0] pat_a(input int k);
        return {(k != 4), 4'((3*k + 1) % 16)};
    endfunction

    function automatic logic [4:0] pat_b(input int k);
        return {1'b1, 4'(15 - k)};
    endfunction

    initial begin
        rst = 1'b1; cs = 1'b1; par_mode = 1'b1; shift_stb = 1'b0; sdi = 1'b0;
        wr_stb = 1'b0; wr_addr = '0; wr_data = '0; wr_bcast = 1'b0; commit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R8";
        check("R8 reset state en", 144'(out_en), 144'd0);
        check("R8 reset state hot", out_hot, 144'd0);

        // R5: broadcast clear, then commit
        cur_req = "R5";
        pwrite(2, 5'h00, 1'b1);
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R5 cleared", k, 1'b0, 0);

        // R2/R4: addressed writes stay hidden until commit
        cur_req = "R2";
        for (int k = 0; k < 9; k++) pwrite(k, pat_a(k), 1'b0);
        check("R2 staged not visible", 144'(out_en), 144'd0);
        cur_req = "R3";
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R3 commit", k, k != 4, (3*k + 1) % 16);
        check_route("R1 disabled dest", 4, 1'b0, 0);

        // R4: out-of-range address stores nothing
        cur_req = "R4";
        pwrite(12, 5'h1F, 1'b0);
        pwrite(9, 5'h1E, 1'b0);
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R4 high addr ignored", k, k != 4, (3*k + 1) % 16);

        // R9: commit ignored with chip select low
        cur_req = "R9";
        pwrite(0, 5'h1A, 1'b0);
        do_commit(1'b0);
        check_route("R9 commit gated", 0, 1'b1, 1);
        pwrite(0, pat_a(0), 1'b0);

        // R8: reset keeps staging, later commit restores
        cur_req = "R8";
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R8 reset disables", 144'(out_en), 144'd0);
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R8 staging kept", k, k != 4, (3*k + 1) % 16);

        // R6/R7: full serial load of pattern B, old contents stream out
        cur_req = "R7";
        par_mode = 1'b0;
        @(negedge clk);
        check("R7 sdo far end", 144'(sdo), 144'(pat_a(8)[4]));
        for (int k = 8; k >= 0; k--)
            for (int b = 4; b >= 0; b--) begin
                check("R7 sdo stream", 144'(sdo), 144'(pat_a(k)[b]));
                shift_bit(pat_b(k)[b], 1'b1);
            end
        check("R2 shift not visible", 144'(out_sel[3:0]), 144'd1);
        cur_req = "R6";
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R6 serial load", k, 1'b1, 15 - k);

        // R9: shifts ignored with chip select low
        cur_req = "R9";
        for (int i = 0; i < 3; i++) shift_bit(1'b0, 1'b0);
        check("R9 shift gated sdo", 144'(sdo), 144'(pat_b(8)[4]));
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R9 shift gated", k, 1'b1, 15 - k);

        // R10: write in serial mode, shift in parallel mode
        cur_req = "R10";
        par_mode = 1'b0; wr_stb = 1'b1; wr_addr = 4'd3; wr_data = 5'h00;
        @(negedge clk);
        wr_stb = 1'b0;
        par_mode = 1'b1;
        shift_bit(1'b0, 1'b1);
        shift_bit(1'b0, 1'b1);
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R10 mode gating", k, 1'b1, 15 - k);

        // R5: broadcast with an out-of-range address
        cur_req = "R5";
        pwrite(13, 5'h17, 1'b1);
        do_commit(1'b1);
        for (int k = 0; k < 9; k++) check_route("R5 broadcast", k, 1'b1, 7);

        // R11: reset beats commit in the same cycle
        cur_req = "R11";
        pwrite(5, 5'h12, 1'b0);
        rst = 1'b1; commit = 1'b1;
        @(negedge clk);
        rst = 1'b0; commit = 1'b0;
        check("R11 reset wins", 144'(out_en), 144'd0);
        do_commit(1'b1);
        check_route("R11 staged after", 5, 1'b1, 2);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule